// File: doc/BRIEF.md
# Raster Timing Generator with Edge Frame

This block produces the raster timing for an analogue colour monitor from one pixel clock. A horizontal position counter steps once per clock and wraps after a full line. A vertical position counter steps each time the horizontal counter wraps, and it wraps after a full frame. Decode logic derives the two sync pulses, the display-enable window, a start-of-frame strobe and the current pixel coordinates. Downstream logic uses these coordinates to paint content.

An optional frame overlay drives the outermost ring of the visible area to full white. Content on a black background often does not reach the screen edges. The white ring still lets a flat-panel monitor's automatic geometry adjustment find where the picture starts and ends. Colour leaves the block as one bit per channel, and the outside resistor network turns these bits into analogue levels.

All sizes are parameters. By default a line is 640 visible pixels plus a 16-clock front porch, a 96-clock sync and a 48-clock back porch, which makes 800 clocks. A frame is 480 visible lines plus 11 front-porch lines, 2 sync lines and 31 back-porch lines, which makes 524 lines. A 25 MHz clock therefore gives about 59.6 frames per second. Other modes such as 720x576 need only new parameter values.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position runs 0 to H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1 and advances every clock. The vertical position advances when the horizontal position wraps and runs 0 to V_ACTIVE+V_FRONT+V_SYNC+V_BACK-1. So `sof_o` repeats exactly every (line total × frame total) clocks.
- R2: The horizontal sync is asserted exactly while the horizontal position p satisfies H_ACTIVE+H_FRONT ≤ p < H_ACTIVE+H_FRONT+H_SYNC.
- R3: The vertical sync is asserted for all clocks of the lines whose vertical position v satisfies V_ACTIVE+V_FRONT ≤ v < V_ACTIVE+V_FRONT+V_SYNC.
- R4: `de_o` is 1 only when the horizontal position is below H_ACTIVE and the vertical position is below V_ACTIVE. Whenever `de_o` is 0, `rgb_o` is 3'b000.
- R5: When `border_on` is 1, `rgb_o` is 3'b111 for visible pixels in column 0, column H_ACTIVE-1, row 0 or row V_ACTIVE-1. All other pixels are 3'b000. The bit order is {red, green, blue}.
- R6: When `border_on` is 0, `rgb_o` is 3'b000 for every pixel, edge pixels included.
- R7: `x_o` and `y_o` equal the horizontal and vertical positions while `de_o` is 1. Both are 0 whenever `de_o` is 0.
- R8: `sof_o` is 1 for exactly one clock per frame, at position (0,0).
- R9: With a polarity parameter at 0 (the default), that sync is active low. With it at 1, that sync is active high. Each sync has its own polarity parameter.
- R10: While `rst` is high at a clock edge, all outputs go idle: syncs inactive, `de_o`, `rgb_o`, `x_o`, `y_o` and `sof_o` at 0. All outputs are registered and describe the same position. The first edge after `rst` falls presents position (0,0), with `sof_o` set and `x_o`, `y_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| border_on | input | 1 | Enables the white edge ring |
| hsync_o | output | 1 | Horizontal sync, polarity from H_SYNC_POL |
| vsync_o | output | 1 | Vertical sync, polarity from V_SYNC_POL |
| rgb_o | output | 3 | Colour bits {red, green, blue} |
| de_o | output | 1 | Display enable (visible pixel) |
| x_o | output | $clog2(H_ACTIVE) | Horizontal pixel coordinate, 0 when blanked |
| y_o | output | $clog2(V_ACTIVE) | Vertical pixel coordinate, 0 when blanked |
| sof_o | output | 1 | One-clock start-of-frame strobe |

## Verification
The bench compares every output, clock by clock, against a position model over whole frames. It does this with a reduced geometry, so off-by-one errors at the porch and sync boundaries show up as a sync pulse one clock or one line too long or too early. It checks the far edges of the ring, the last column and last row. A design that decodes the ring against the wrong limit would paint a blanked pixel or miss the right edge. It also confirms that disabling the ring leaves even the edges black. Reset is exercised at start-up and in mid-frame: a design that realigned its outputs wrongly would show (0,0) one clock late or miss the start-of-frame strobe. A second instance with active-high syncs catches a polarity parameter that has no effect.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic active;  // position inside visible span
    logic sync;    // position inside sync span
    logic rim;     // first or last visible position
  } axis_flags_t;

  localparam logic [2:0] RGB_BLACK = 3'b000;
  localparam logic [2:0] RGB_WHITE = 3'b111;
endpackage

// File: rtl/raster_axis_ctr.sv
module raster_axis_ctr #(
  parameter int TOTAL = 800,
  localparam int W = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (step)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode
  import raster_pkg::*;
#(
  parameter int ACTIVE = 640,
  parameter int FRONT  = 16,
  parameter int SYNC   = 96,
  parameter int W      = 10
) (
  input  logic [W-1:0] pos,
  output axis_flags_t  flags
);
  localparam int SYNC_START = ACTIVE + FRONT;
  localparam int SYNC_STOP  = SYNC_START + SYNC;

  always_comb begin
    flags.active = int'(pos) < ACTIVE;
    flags.sync   = (int'(pos) >= SYNC_START) && (int'(pos) < SYNC_STOP);
    flags.rim    = (int'(pos) == 0) || (int'(pos) == ACTIVE - 1);
  end
endmodule

// File: rtl/raster_out_reg.sv
module raster_out_reg
  import raster_pkg::*;
#(
  parameter int   HW    = 10,
  parameter int   VW    = 10,
  parameter int   XW    = 10,
  parameter int   YW    = 9,
  parameter bit   H_POL = 1'b0,
  parameter bit   V_POL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          border_on,
  input  axis_flags_t   hf,
  input  axis_flags_t   vf,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [2:0]    rgb_o,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          sof_o
);
  logic visible, on_ring, hs_lvl, vs_lvl;

  assign visible = hf.active && vf.active;
  assign on_ring = visible && (hf.rim || vf.rim);

  generate
    if (H_POL) begin : g_hs_high
      assign hs_lvl = hf.sync;
    end else begin : g_hs_low
      assign hs_lvl = ~hf.sync;
    end
    if (V_POL) begin : g_vs_high
      assign vs_lvl = vf.sync;
    end else begin : g_vs_low
      assign vs_lvl = ~vf.sync;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= ~H_POL;
      vsync_o <= ~V_POL;
      rgb_o   <= RGB_BLACK;
      de_o    <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      sof_o   <= 1'b0;
    end else begin
      hsync_o <= hs_lvl;
      vsync_o <= vs_lvl;
      rgb_o   <= (border_on && on_ring) ? RGB_WHITE : RGB_BLACK;
      de_o    <= visible;
      x_o     <= visible ? hpos[XW-1:0] : '0;
      y_o     <= visible ? vpos[YW-1:0] : '0;
      sof_o   <= (hpos == '0) && (vpos == '0);
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 11,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 31,
  parameter bit H_SYNC_POL = 1'b0,
  parameter bit V_SYNC_POL = 1'b0,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          border_on,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [2:0]    rgb_o,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          sof_o
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end;
  axis_flags_t   hflags, vflags;

  assign line_end = (hcnt == HW'(H_TOTAL - 1));

  raster_axis_ctr #(.TOTAL(H_TOTAL)) u_hctr (
    .clk(clk), .rst(rst), .step(1'b1), .cnt(hcnt)
  );

  raster_axis_ctr #(.TOTAL(V_TOTAL)) u_vctr (
    .clk(clk), .rst(rst), .step(line_end), .cnt(vcnt)
  );

  raster_axis_decode #(.ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .W(HW)) u_hdec (
    .pos(hcnt), .flags(hflags)
  );

  raster_axis_decode #(.ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .W(VW)) u_vdec (
    .pos(vcnt), .flags(vflags)
  );

  raster_out_reg #(
    .HW(HW), .VW(VW), .XW(XW), .YW(YW), .H_POL(H_SYNC_POL), .V_POL(V_SYNC_POL)
  ) u_out (
    .clk(clk), .rst(rst), .border_on(border_on),
    .hf(hflags), .vf(vflags), .hpos(hcnt), .vpos(vcnt),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .rgb_o(rgb_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o), .sof_o(sof_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int HA = 640,
  parameter int XW = 10,
  parameter int YW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          border_on,
  input logic          de_o,
  input logic [2:0]    rgb_o,
  input logic [XW-1:0] x_o,
  input logic [YW-1:0] y_o,
  input logic          sof_o
);
  // R4
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> rgb_o == 3'b000);

  // R7
  coord_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (x_o == '0 && y_o == '0));

  // R1
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (de_o && int'(x_o) != HA - 1) |=> (de_o && x_o == $past(x_o) + 1'b1));

  // R8
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    sof_o |=> !sof_o);

  // R6
  ring_off_chk: assert property (@(posedge clk) disable iff (rst)
    !border_on |=> rgb_o == 3'b000);

  // R5
  ring_level_chk: assert property (@(posedge clk) disable iff (rst)
    (rgb_o == 3'b000) || (rgb_o == 3'b111));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!de_o && rgb_o == 3'b000 && !sof_o));
endmodule

bind raster_timing_gen raster_timing_chk #(.HA(H_ACTIVE), .XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .border_on(border_on), .de_o(de_o), .rgb_o(rgb_o),
  .x_o(x_o), .y_o(y_o), .sof_o(sof_o)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic border_on = 1'b1;
  always #4 clk = ~clk;

  logic       hs, vs, de, sof, hs_p, vs_p, de_p, sof_p;
  logic [2:0] rgb, rgb_p, x, x_p, y, y_p;

  raster_timing_gen #(.H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
                      .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)) dut (
    .clk(clk), .rst(rst), .border_on(border_on), .hsync_o(hs), .vsync_o(vs),
    .rgb_o(rgb), .de_o(de), .x_o(x), .y_o(y), .sof_o(sof));

  raster_timing_gen #(.H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
                      .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
                      .H_SYNC_POL(1'b1), .V_SYNC_POL(1'b1)) dut_pos (
    .clk(clk), .rst(rst), .border_on(border_on), .hsync_o(hs_p), .vsync_o(vs_p),
    .rgb_o(rgb_p), .de_o(de_p), .x_o(x_p), .y_o(y_p), .sof_o(sof_p));

  int checks = 0;
  int errors = 0;

  // Position model built from the requirements
  int mh = 0, mv = 0, ph = 0, pv = 0;
  bit pb = 1'b0, pvld = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      mh <= 0; mv <= 0; pvld <= 1'b0;
    end else begin
      ph <= mh; pv <= mv; pb <= border_on; pvld <= 1'b1;
      if (mh == HT - 1) begin
        mh <= 0;
        mv <= (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh <= mh + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d,%0d)", tag, act, exp, ph, pv);
    end
  endtask

  task automatic check_now();
    bit e_de, e_hs, e_vs, e_rim;
    if (!pvld) begin
      chk("R10 hsync idle", hs, 1); chk("R10 vsync idle", vs, 1);
      chk("R10 de idle", de, 0);    chk("R10 rgb idle", rgb, 0);
      chk("R10 x idle", x, 0);      chk("R10 y idle", y, 0);
      chk("R10 sof idle", sof, 0);
      chk("R9 pos hsync idle", hs_p, 0); chk("R9 pos vsync idle", vs_p, 0);
    end else begin
      e_de  = (ph < HA) && (pv < VA);
      e_hs  = (ph >= HA + HF) && (ph < HA + HF + HS);
      e_vs  = (pv >= VA + VF) && (pv < VA + VF + VS);
      e_rim = e_de && (ph == 0 || ph == HA - 1 || pv == 0 || pv == VA - 1);
      chk("R2 hsync", hs, !e_hs);
      chk("R3 vsync", vs, !e_vs);
      chk("R4 de", de, e_de);
      if (pb) chk("R5 rgb ring", rgb, e_rim ? 7 : 0);
      else    chk("R6 rgb off", rgb, 0);
      chk("R7 x", x, e_de ? ph : 0);
      chk("R7 y", y, e_de ? pv : 0);
      chk("R8 sof", sof, (ph == 0 && pv == 0));
      chk("R9 pos hsync", hs_p, e_hs);
      chk("R9 pos vsync", vs_p, e_vs);
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  // R10: idle during reset, (0,0) first after release
  task automatic t_reset_start();
    rst = 1'b1;
    run_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 first de", de, 1);
    chk("R10 first sof", sof, 1);
    chk("R10 first x", x, 0);
    chk("R10 first y", y, 0);
  endtask

  // R2 R3 R4 R5 R7 R8 R9: full frame with ring on
  task automatic t_frame_ring();
    border_on = 1'b1;
    run_cycles(VT * HT + 5);
  endtask

  // R6: ring disabled, edges must stay black
  task automatic t_frame_plain();
    int lit = 0;
    border_on = 1'b0;
    for (int i = 0; i < VT * HT + 2; i++) begin
      @(negedge clk);
      check_now();
      if (rgb != 3'b000) lit++;
    end
    chk("R6 lit pixels with ring off", lit, 0);
    border_on = 1'b1;
  endtask

  // R1 R8: spacing of start-of-frame strobes
  task automatic t_sof_period();
    int gap = 0;
    int pulses = 0;
    do begin @(negedge clk); check_now(); end while (!sof);
    do begin @(negedge clk); check_now(); gap++; if (sof) pulses++; end while (!sof);
    chk("R1 frame period", gap, HT * VT);
    chk("R8 one sof per frame", pulses, 1);
  endtask

  // R10: reset mid frame
  task automatic t_mid_reset();
    run_cycles(HT * 3 + 4);
    rst = 1'b1;
    run_cycles(2);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 resume sof", sof, 1);
    chk("R10 resume x", x, 0);
    chk("R10 resume y", y, 0);
    run_cycles(HT * 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_start();
    t_frame_ring();
    t_frame_plain();
    t_sof_period();
    t_mid_reset();
    t_frame_ring();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule